// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block is the dedicated last-in first-out store of a small processor. It keeps subroutine return addresses, interrupt return addresses and general-purpose values. The call, return, push and pop logic elsewhere in the core shows up here only as two strobes, a push with its data word and a pop. A third input marks a pop as the interrupt-return kind. The stack has no address in program or data space. The only way to reach it is through these strobes.

The pointer indexes the top entry. It leaves reset at the highest index, so the first push wraps it to entry 0. A push first advances the pointer and then writes at the new index. A pop reads the entry under the current pointer and then steps the pointer back. The read port is combinational, so the top word is always available for the pop that consumes it. Pointer arithmetic wraps modulo the depth. A separate occupancy count drives two sticky flags that expose overflow and underflow. An interrupt-return pop produces a one-cycle clear pulse for the in-service flag held by the interrupt logic. Entry contents are not reset.

Top module: `hw_ret_stack`

## Requirements
- R1: While and after reset, `sp_o` is 15 (`DEPTH-1`), and `ovf_o`, `unf_o` and `isr_clr_o` are 0. Stack contents are not initialised.
- R2: A push without a pop, on the clock edge, sets `sp_o` to its old value plus one modulo 16 (15 wraps to 0) and writes `push_data_i` at that new index. From the next cycle, `top_data_o` shows the pushed word.
- R3: `top_data_o` always shows, combinationally, the entry at the current `sp_o`. A pop without a push delivers that word and, on the clock edge, sets `sp_o` to its old value minus one modulo 16 (0 wraps to 15).
- R4: Values come back in reverse order of pushing.
- R5: A pop with `pop_irq_i`=1 changes pointer and data exactly like a plain pop, and raises `isr_clr_o` for exactly the following cycle. When `pop_i`=0, `pop_irq_i` has no effect on any output.
- R6: A push and a pop in the same cycle replace the top entry with `push_data_i` and leave `sp_o` unchanged. This counts as one held entry, never raises a flag, and pulses `isr_clr_o` if `pop_irq_i`=1.
- R7: A push without a pop while 16 entries are held sets `ovf_o`. The pointer still wraps and the entry is overwritten. `ovf_o` stays 1 until reset.
- R8: A pop without a push while no entries are held sets `unf_o`. The pointer still wraps. `unf_o` stays 1 until reset.
- R9: With neither strobe asserted, `sp_o`, `top_data_o` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call, interrupt vectoring, explicit push) |
| push_data_i | input | 16 | Word to store on a push |
| pop_i | input | 1 | Pop strobe (return, explicit pop) |
| pop_irq_i | input | 1 | Marks the pop as an interrupt return |
| top_data_o | output | 16 | Entry at the current pointer, combinational |
| sp_o | output | 4 | Current stack pointer |
| isr_clr_o | output | 1 | One-cycle clear pulse for the in-service flag |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Short directed sequences push distinct words and pop them back. This separates true reverse-order recovery from a pointer that moves but reads the wrong slot. The bench then walks the pointer through its 15-to-0 wrap, fills the stack past its depth, and pops from an empty stack. These cases tell wrap arithmetic apart from the occupancy-based flags. Combined push-and-pop cycles and interrupt-marked pops, with and without the pop strobe, separate the replace-top path and the clear pulse from the plain pop path. A long seeded random mix of all four strobe combinations is compared every cycle against a reference model held in the bench.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int unsigned RS_DATA_W = 16;
    localparam int unsigned RS_DEPTH  = 16;

    // Combined strobe meaning for one cycle
    typedef enum logic [1:0] {
        RS_IDLE = 2'b00,
        RS_POP  = 2'b01,
        RS_PUSH = 2'b10,
        RS_SWAP = 2'b11
    } rs_op_e;

    function automatic rs_op_e rs_decode(input logic push, input logic pop);
        rs_op_e op;
        unique case ({push, pop})
            2'b10:   op = RS_PUSH;
            2'b01:   op = RS_POP;
            2'b11:   op = RS_SWAP;
            default: op = RS_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
    import rs_pkg::*;
#(
    parameter int unsigned DEPTH = RS_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rs_op_e           op,
    input  logic             irq_ret,
    output logic [PTR_W-1:0] sp,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             ovf,
    output logic             unf,
    output logic             isr_clr
);

    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             unf;
        logic             clr;
    } ctrl_t;

    ctrl_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == TOP_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? TOP_IDX : p - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = st_q.sp;
        unique case (op)
            RS_PUSH: begin
                st_d.sp = ptr_inc(st_q.sp);
                wr_en   = 1'b1;
                wr_addr = ptr_inc(st_q.sp);
                if (st_q.cnt == FULL) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            RS_POP: begin
                st_d.sp  = ptr_dec(st_q.sp);
                st_d.clr = irq_ret;
                if (st_q.cnt == '0) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            RS_SWAP: begin
                wr_en    = 1'b1;
                wr_addr  = st_q.sp;
                st_d.clr = irq_ret;
                if (st_q.cnt == '0) begin
                    st_d.cnt = CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sp: TOP_IDX, cnt: '0, ovf: 1'b0, unf: 1'b0, clr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sp      = st_q.sp;
    assign ovf     = st_q.ovf;
    assign unf     = st_q.unf;
    assign isr_clr = st_q.clr;

endmodule

// File: rtl/rs_store.sv
module rs_store
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = RS_DATA_W,
    parameter int unsigned DEPTH  = RS_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    // Entries carry no reset: contents are undefined until written
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hw_ret_stack.sv
module hw_ret_stack
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = RS_DATA_W,
    parameter int unsigned DEPTH  = RS_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              pop_irq_i,
    output logic [DATA_W-1:0] top_data_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              isr_clr_o,
    output logic              ovf_o,
    output logic              unf_o
);

    rs_op_e           op;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] sp;

    assign op = rs_decode(push_i, pop_i);

    rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .irq_ret (pop_irq_i),
        .sp      (sp),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ovf     (ovf_o),
        .unf     (unf_o),
        .isr_clr (isr_clr_o)
    );

    rs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (push_data_i),
        .rd_addr (sp),
        .rd_data (top_data_o)
    );

    assign sp_o = sp;

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic [DATA_W-1:0] push_data_i,
    input logic              pop_i,
    input logic              pop_irq_i,
    input logic [DATA_W-1:0] top_data_o,
    input logic [PTR_W-1:0]  sp_o,
    input logic              isr_clr_o,
    input logic              ovf_o,
    input logic              unf_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_o == PTR_W'(DEPTH - 1)) && !ovf_o && !unf_o && !isr_clr_o);

    // R2
    push_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> sp_o == PTR_W'($past(sp_o) + 1'b1));

    // R2
    push_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> top_data_o == $past(push_data_i));

    // R3
    pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> sp_o == PTR_W'($past(sp_o) - 1'b1));

    // R5
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && pop_irq_i) |=> isr_clr_o);

    // R5
    no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && pop_irq_i) |=> !isr_clr_o);

    // R6
    swap_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(sp_o) && top_data_o == $past(push_data_i));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(sp_o) && $stable(top_data_o) && $stable(ovf_o) && $stable(unf_o));

endmodule

bind hw_ret_stack rs_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_irq_i   (pop_irq_i),
    .top_data_o  (top_data_o),
    .sp_o        (sp_o),
    .isr_clr_o   (isr_clr_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/hw_ret_stack_bench.sv
module hw_ret_stack_bench;

    localparam int DW = 16;
    localparam int DP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [DW-1:0] push_data_i = '0;
    logic          pop_i = 1'b0;
    logic          pop_irq_i = 1'b0;
    logic [DW-1:0] top_data_o;
    logic [3:0]    sp_o;
    logic          isr_clr_o;
    logic          ovf_o;
    logic          unf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model
    logic [DW-1:0] m_mem [DP];
    bit            m_val [DP];
    int            m_sp, m_cnt;
    bit            m_ovf, m_unf, m_clr;

    always #10 clk = ~clk;  // 50 MHz

    hw_ret_stack u_hw_ret_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_irq_i(pop_irq_i), .top_data_o(top_data_o),
        .sp_o(sp_o), .isr_clr_o(isr_clr_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wrap_inc(input int p);
        return (p + 1) % DP;
    endfunction

    function automatic int wrap_dec(input int p);
        return (p + DP - 1) % DP;
    endfunction

    task automatic model_reset();
        m_sp = DP - 1; m_cnt = 0; m_ovf = 0; m_unf = 0; m_clr = 0;
        for (int i = 0; i < DP; i++) m_val[i] = 0;
    endtask

    task automatic compare(input string req);
        check(sp_o == 4'(m_sp), req, "sp", int'(sp_o), m_sp);
        check(ovf_o == m_ovf, req, "ovf", int'(ovf_o), int'(m_ovf));
        check(unf_o == m_unf, req, "unf", int'(unf_o), int'(m_unf));
        check(isr_clr_o == m_clr, req, "isr_clr", int'(isr_clr_o), int'(m_clr));
        if (m_val[m_sp])
            check(top_data_o == m_mem[m_sp], req, "top", int'(top_data_o), int'(m_mem[m_sp]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 0; pop_i = 0; pop_irq_i = 0;
        repeat (2) @(negedge clk);
        model_reset();
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
    endtask

    // Apply one cycle of strobes at a falling edge, update model, check at next falling edge
    task automatic step(input bit ps, input bit pp, input bit irq,
                        input logic [DW-1:0] d, input string req);
        push_i = ps; pop_i = pp; pop_irq_i = irq; push_data_i = d;
        if (pp && m_val[m_sp])
            check(top_data_o == m_mem[m_sp], "R3", "pop data", int'(top_data_o), int'(m_mem[m_sp]));
        @(negedge clk);
        m_clr = pp && irq;
        if (ps && pp) begin
            m_mem[m_sp] = d; m_val[m_sp] = 1;
            if (m_cnt == 0) m_cnt = 1;
        end else if (ps) begin
            m_sp = wrap_inc(m_sp);
            m_mem[m_sp] = d; m_val[m_sp] = 1;
            if (m_cnt == DP) m_ovf = 1; else m_cnt++;
        end else if (pp) begin
            if (m_cnt == 0) m_unf = 1; else m_cnt--;
            m_sp = wrap_dec(m_sp);
        end
        push_i = 0; pop_i = 0; pop_irq_i = 0;
        compare(req);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                wait (done);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        do_reset();

        // R2: first push wraps 15 -> 0
        step(1, 0, 0, 16'hA001, "R2");
        check(sp_o == 4'd0, "R2", "first push index", int'(sp_o), 0);
        step(1, 0, 0, 16'hB002, "R2");
        step(1, 0, 0, 16'hC003, "R2");
        // R9: idle holds, and R5: irq flag without pop is ignored
        step(0, 0, 0, 16'hFFFF, "R9");
        step(0, 0, 1, 16'hEEEE, "R5");
        check(isr_clr_o == 1'b0, "R5", "irq without pop", int'(isr_clr_o), 0);
        // R4: reverse order
        check(top_data_o == 16'hC003, "R4", "lifo 1", int'(top_data_o), 'hC003);
        step(0, 1, 0, 0, "R4");
        check(top_data_o == 16'hB002, "R4", "lifo 2", int'(top_data_o), 'hB002);
        // R5: interrupt-return pop
        step(0, 1, 1, 0, "R5");
        check(isr_clr_o == 1'b1, "R5", "clr pulse", int'(isr_clr_o), 1);
        check(top_data_o == 16'hA001, "R4", "lifo 3", int'(top_data_o), 'hA001);
        step(0, 0, 0, 0, "R5");
        check(isr_clr_o == 1'b0, "R5", "pulse width", int'(isr_clr_o), 0);
        // R6: replace top
        step(1, 1, 1, 16'h5A5A, "R6");
        check(top_data_o == 16'h5A5A && sp_o == 4'd0, "R6", "replace top",
              int'(top_data_o), 'h5A5A);
        step(0, 1, 0, 0, "R3");
        check(sp_o == 4'd15, "R3", "pop wrap 0->15", int'(sp_o), 15);

        // R8: underflow
        step(0, 1, 0, 0, "R8");
        check(unf_o == 1'b1, "R8", "underflow flag", int'(unf_o), 1);
        step(1, 0, 0, 16'h1111, "R8");
        check(unf_o == 1'b1, "R8", "sticky", int'(unf_o), 1);

        // R7: overflow after a full stack
        do_reset();
        for (int i = 0; i < DP; i++) step(1, 0, 0, DW'(16'h2000 + i), "R7");
        check(ovf_o == 1'b0, "R7", "full no ovf", int'(ovf_o), 0);
        step(1, 0, 0, 16'hDEAD, "R7");
        check(ovf_o == 1'b1 && sp_o == 4'd0, "R7", "overflow flag", int'(ovf_o), 1);
        step(0, 1, 0, 0, "R7");
        check(ovf_o == 1'b1, "R7", "sticky", int'(ovf_o), 1);

        // Random mix
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 8);
            step(r[0], r[1], r[2], DW'($urandom), "R4");
            if ((i % 700) == 699) do_reset();
        end

        done = 1'b1;
    end

endmodule